// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin Override Multiplexer

This block controls an 8-pin general-purpose I/O port. A small register interface holds a per-pin direction register, an output latch and a global weak pull-up enable. The pin levels are read back through a two-flop synchronizer. For each pad the block produces output data, output enable and pull-up enable.

Several on-chip functions can take pins away from the GPIO latch, and each has its own configuration input. A multiplexed external address/data bus can claim all eight pins. Parallel-port write and read strobes can claim pins 1 and 0. PWM outputs can claim pins according to two remap inputs. A reference clock can claim pin 3. A fixed priority decides which function owns each pin. The pull-up on a pin switches off whenever that pin is driven.

Top module: `gpio_port`

## Requirements
- R1: After reset, direction reads 0xFF (all inputs), the latch is 0x00, the pull-up enable is 0, the synchronizer holds 0, and with no override active every `pad_oe_o` and `pad_pu_o` bit is 0.
- R2: A direction bit of 1 makes the pin an input and 0 makes it an output. A pin owned by the GPIO path has `pad_oe_o[k] = ~dir[k]` and `pad_do_o[k] = latch[k]`. Writing 0x03 leaves pins 1:0 as inputs and pins 7:2 as outputs.
- R3: Register addresses are 0 = port, 1 = latch, 2 = direction and 3 = control, where control bit 0 is the pull-up enable. A write to address 0 or address 1 loads the latch at the next clock edge. Reads are combinational: address 1 returns the latch, address 2 the direction and address 3 returns `{7'b0, pu_en}`.
- R4: A read of address 0 returns `pin_i` as sampled two rising clock edges earlier.
- R5: `pad_pu_o[k] = pu_en & ~pad_oe_o[k]` for every pin.
- R6: When `ext_bus_dis_i` is 0, every pin has `pad_oe_o[k] = bus_oe_i` and `pad_do_o[k] = bus_do_i[k]`. The direction register and all other overrides are ignored.
- R7: When the bus is disabled and `strobe_sel_n_i` is 0, pin 1 drives `strobe_wr_i` and pin 0 drives `strobe_rd_i`, both with the output enable at 1.
- R8: PWM channel k may claim pin k under these rules. Pins 2:0 are always eligible. Pins 6:3 are eligible only when `pwm_pairs_here_i` is 1. Pin 7 is eligible only when `pwm_pin7_en_i` is 1. An eligible pin with `pwm_oe_i[k]` = 1 has its output enable at 1 and drives `pwm_do_i[k]`.
- R9: When `refclk_en_i` is 1, pin 3 has its output enable at 1 and drives `refclk_i`.
- R10: Ownership priority per pin is external bus, then strobes, then PWM, then reference clock, then the GPIO latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| pin_i | input | 8 | Pad input levels |
| pad_do_o | output | 8 | Pad output data |
| pad_oe_o | output | 8 | Pad output enable |
| pad_pu_o | output | 8 | Pad weak pull-up enable |
| ext_bus_dis_i | input | 1 | 0 = external bus owns all pins |
| bus_do_i | input | 8 | External bus high-byte output data |
| bus_oe_i | input | 1 | External bus output enable |
| strobe_sel_n_i | input | 1 | 0 = strobes own pins 1:0 |
| strobe_wr_i | input | 1 | Parallel write strobe |
| strobe_rd_i | input | 1 | Parallel read strobe |
| pwm_pairs_here_i | input | 1 | 1 = PWM pairs stay on pins 6:3 |
| pwm_pin7_en_i | input | 1 | 1 = PWM channel 7 may use pin 7 |
| pwm_do_i | input | 8 | PWM output data per pin |
| pwm_oe_i | input | 8 | PWM output enable per pin |
| refclk_en_i | input | 1 | 1 = reference clock owns pin 3 |
| refclk_i | input | 1 | Reference clock |

## Verification
The pad outputs and register reads are combinational from the control inputs. They settle in the same cycle an input changes and, after a write, right after the next rising edge. A read of address 0 reflects `pin_i` only after two rising edges. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass and compares on the following falling edge. Its synchronizer model shifts once per rising edge, so the expected port value lags `pin_i` by the two registers in the path.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int SYNC_STAGES = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LAT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

  // PWM eligibility per pin
  localparam logic [PORT_W-1:0] PWM_FIXED_MASK = 8'h07;
  localparam logic [PORT_W-1:0] PWM_PAIR_MASK  = 8'h78;
  localparam logic [PORT_W-1:0] PWM_PIN7_MASK  = 8'h80;

  localparam int REFCLK_PIN = 3;
  localparam int STROBE_WR_PIN = 1;
  localparam int STROBE_RD_PIN = 0;

  typedef enum logic [2:0] {
    OWN_BUS, OWN_STROBE, OWN_PWM, OWN_REFCLK, OWN_GPIO
  } pin_owner_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pin_sync_i,
  output logic [PORT_W-1:0] lat_o,
  output logic [PORT_W-1:0] dir_o,
  output logic              pu_en_o,
  output logic [PORT_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_o   <= '0;
      dir_o   <= '1;
      pu_en_o <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_PORT, ADDR_LAT: lat_o <= wdata_i;
        ADDR_DIR:            dir_o <= wdata_i;
        default:             pu_en_o <= wdata_i[0];
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_PORT: rdata_o = pin_sync_i;
      ADDR_LAT:  rdata_o = lat_o;
      ADDR_DIR:  rdata_o = dir_o;
      default:   rdata_o = {{(PORT_W-1){1'b0}}, pu_en_o};
    endcase
  end

  AST_LAT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == ADDR_PORT || addr_i == ADDR_LAT) |=> lat_o == $past(wdata_i)); // R3
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_DIR |=> dir_o == $past(wdata_i)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_DIR) |=> $stable(dir_o)); // R2
endmodule

// File: rtl/gpio_port_pin_mux.sv
module gpio_port_pin_mux
  import gpio_port_pkg::*;
(
  input  logic [PORT_W-1:0] lat_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              ext_bus_dis_i,
  input  logic [PORT_W-1:0] bus_do_i,
  input  logic              bus_oe_i,
  input  logic              strobe_sel_n_i,
  input  logic              strobe_wr_i,
  input  logic              strobe_rd_i,
  input  logic              pwm_pairs_here_i,
  input  logic              pwm_pin7_en_i,
  input  logic [PORT_W-1:0] pwm_do_i,
  input  logic [PORT_W-1:0] pwm_oe_i,
  input  logic              refclk_en_i,
  input  logic              refclk_i,
  output logic [PORT_W-1:0] pad_do_o,
  output logic [PORT_W-1:0] pad_oe_o
);
  logic [PORT_W-1:0] pwm_elig;
  assign pwm_elig = PWM_FIXED_MASK
                  | (PWM_PAIR_MASK & {PORT_W{pwm_pairs_here_i}})
                  | (PWM_PIN7_MASK & {PORT_W{pwm_pin7_en_i}});

  for (genvar k = 0; k < PORT_W; k++) begin : g_pin
    localparam bit IS_STROBE = (k == STROBE_WR_PIN) || (k == STROBE_RD_PIN);
    localparam bit IS_REFCLK = (k == REFCLK_PIN);
    pin_owner_e owner;
    logic strobe_val;

    assign strobe_val = (k == STROBE_WR_PIN) ? strobe_wr_i : strobe_rd_i;

    always_comb begin
      if (!ext_bus_dis_i)                     owner = OWN_BUS;
      else if (IS_STROBE && !strobe_sel_n_i)  owner = OWN_STROBE;
      else if (pwm_elig[k] && pwm_oe_i[k])    owner = OWN_PWM;
      else if (IS_REFCLK && refclk_en_i)      owner = OWN_REFCLK;
      else                                    owner = OWN_GPIO;
    end

    always_comb begin
      case (owner)
        OWN_BUS:    begin pad_oe_o[k] = bus_oe_i; pad_do_o[k] = bus_do_i[k]; end
        OWN_STROBE: begin pad_oe_o[k] = 1'b1;     pad_do_o[k] = strobe_val;  end
        OWN_PWM:    begin pad_oe_o[k] = 1'b1;     pad_do_o[k] = pwm_do_i[k]; end
        OWN_REFCLK: begin pad_oe_o[k] = 1'b1;     pad_do_o[k] = refclk_i;    end
        default:    begin pad_oe_o[k] = ~dir_i[k]; pad_do_o[k] = lat_i[k];   end
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pad_do_o,
  output logic [PORT_W-1:0] pad_oe_o,
  output logic [PORT_W-1:0] pad_pu_o,
  input  logic              ext_bus_dis_i,
  input  logic [PORT_W-1:0] bus_do_i,
  input  logic              bus_oe_i,
  input  logic              strobe_sel_n_i,
  input  logic              strobe_wr_i,
  input  logic              strobe_rd_i,
  input  logic              pwm_pairs_here_i,
  input  logic              pwm_pin7_en_i,
  input  logic [PORT_W-1:0] pwm_do_i,
  input  logic [PORT_W-1:0] pwm_oe_i,
  input  logic              refclk_en_i,
  input  logic              refclk_i
);
  logic [PORT_W-1:0] lat_q, dir_q, pin_sync;
  logic              pu_en_q;

  gpio_port_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_port_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pin_sync_i(pin_sync), .lat_o(lat_q), .dir_o(dir_q),
    .pu_en_o(pu_en_q), .rdata_o
  );

  gpio_port_pin_mux u_mux (
    .lat_i(lat_q), .dir_i(dir_q),
    .ext_bus_dis_i, .bus_do_i, .bus_oe_i,
    .strobe_sel_n_i, .strobe_wr_i, .strobe_rd_i,
    .pwm_pairs_here_i, .pwm_pin7_en_i, .pwm_do_i, .pwm_oe_i,
    .refclk_en_i, .refclk_i,
    .pad_do_o, .pad_oe_o
  );

  // pull-up only on undriven pins
  assign pad_pu_o = {PORT_W{pu_en_q}} & ~pad_oe_o;

  // cycles since reset, for the synchronizer latency check
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst_q >= 2'd2 |-> pin_sync == $past(pin_i, 2)); // R4
  AST_PU_OFF_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0); // R5
  AST_BUS_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_bus_dis_i |-> pad_oe_o == {PORT_W{bus_oe_i}} && pad_do_o == bus_do_i); // R6
  AST_STROBE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_bus_dis_i && !strobe_sel_n_i |->
      pad_oe_o[1:0] == 2'b11 && pad_do_o[1:0] == {strobe_wr_i, strobe_rd_i}); // R7
  AST_GPIO_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_bus_dis_i && strobe_sel_n_i && pwm_oe_i == '0 && !refclk_en_i |->
      pad_oe_o == ~dir_q && pad_do_o == lat_q); // R2
  AST_REFCLK_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_bus_dis_i && refclk_en_i && !(pwm_pairs_here_i && pwm_oe_i[REFCLK_PIN]) |->
      pad_oe_o[REFCLK_PIN] && pad_do_o[REFCLK_PIN] == refclk_i); // R9
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o, pad_do_o, pad_oe_o, pad_pu_o;
  logic [7:0] pin_i = 8'h00;
  logic       ext_bus_dis_i = 1'b1;
  logic [7:0] bus_do_i = 8'h00;
  logic       bus_oe_i = 1'b0;
  logic       strobe_sel_n_i = 1'b1;
  logic       strobe_wr_i = 1'b0, strobe_rd_i = 1'b0;
  logic       pwm_pairs_here_i = 1'b1, pwm_pin7_en_i = 1'b0;
  logic [7:0] pwm_do_i = 8'h00, pwm_oe_i = 8'h00;
  logic       refclk_en_i = 1'b0, refclk_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_lat = 8'h00, m_dir = 8'hFF, m_s1 = 8'h00, m_s2 = 8'h00;
  logic       m_pu = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_port uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pads();
    logic [7:0] oe, dout;
    for (int k = 0; k < 8; k++) begin
      logic elig;
      elig = (k < 3) || (k >= 3 && k <= 6 && pwm_pairs_here_i) || (k == 7 && pwm_pin7_en_i);
      if (!ext_bus_dis_i) begin oe[k] = bus_oe_i; dout[k] = bus_do_i[k]; end
      else if (k < 2 && !strobe_sel_n_i) begin
        oe[k] = 1'b1; dout[k] = (k == 1) ? strobe_wr_i : strobe_rd_i;
      end
      else if (elig && pwm_oe_i[k]) begin oe[k] = 1'b1; dout[k] = pwm_do_i[k]; end
      else if (k == 3 && refclk_en_i) begin oe[k] = 1'b1; dout[k] = refclk_i; end
      else begin oe[k] = ~m_dir[k]; dout[k] = m_lat[k]; end
    end
    return {oe, dout};
  endfunction

  function automatic logic [7:0] exp_rd();
    case (addr_i)
      2'd0: return m_s2;
      2'd1: return m_lat;
      2'd2: return m_dir;
      default: return {7'b0, m_pu};
    endcase
  endfunction

  // inputs already driven; pass one rising edge, compare on next falling edge
  task automatic cycle_and_check(input string tag);
    logic [15:0] e;
    @(posedge clk_i);
    if (wr_en_i) begin
      case (addr_i)
        2'd0, 2'd1: m_lat = wdata_i;
        2'd2: m_dir = wdata_i;
        default: m_pu = wdata_i[0];
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pin_i;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    e = exp_pads();
    chk({tag, " R10 pad_oe"}, pad_oe_o, e[15:8]);
    chk({tag, " R10 pad_do"}, pad_do_o, e[7:0]);
    chk({tag, " R5 pad_pu"}, pad_pu_o, {8{m_pu}} & ~e[15:8]);
    chk({tag, " R3/R4 rdata"}, rdata_o, exp_rd());
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    cycle_and_check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset oe", pad_oe_o, 8'h00);
    chk("R1 reset pu", pad_pu_o, 8'h00);
    addr_i = 2'd2; #1 chk("R1 reset dir", rdata_o, 8'hFF);
    addr_i = 2'd1; #1 chk("R1 reset lat", rdata_o, 8'h00);
    addr_i = 2'd0; #1 chk("R1 reset sync", rdata_o, 8'h00);
    rst_ni = 1'b1;

    // R2: 0x03 -> pins 1:0 in, 7:2 out
    reg_write(2'd2, 8'h03, "R2 dir03");
    chk("R2 oe after 0x03", pad_oe_o, 8'hFC);
    reg_write(2'd0, 8'hA5, "R3 lat via port");
    chk("R3 latch on pads", pad_do_o, 8'hA5);
    addr_i = 2'd1; cycle_and_check("R3 read lat");
    reg_write(2'd1, 8'h3C, "R3 lat via lat");
    reg_write(2'd3, 8'h01, "R5 pu on");
    chk("R5 pu only inputs", pad_pu_o, 8'h03);

    // R4: pin change seen after two edges
    pin_i = 8'h5A; addr_i = 2'd0;
    cycle_and_check("R4 edge1");
    chk("R4 not yet", rdata_o, 8'h00);
    cycle_and_check("R4 edge2");
    chk("R4 arrived", rdata_o, 8'h5A);

    // R6: bus overrides direction
    ext_bus_dis_i = 1'b0; bus_oe_i = 1'b1; bus_do_i = 8'hC3;
    cycle_and_check("R6 bus drive");
    chk("R6 bus oe", pad_oe_o, 8'hFF);
    bus_oe_i = 1'b0;
    cycle_and_check("R6 bus input");
    chk("R6 pu when bus reads", pad_pu_o, 8'hFF);
    ext_bus_dis_i = 1'b1;

    // R7/R8/R9/R10 directed priority
    strobe_sel_n_i = 1'b0; strobe_wr_i = 1'b1; strobe_rd_i = 1'b0;
    pwm_oe_i = 8'hFF; pwm_do_i = 8'h00; refclk_en_i = 1'b1; refclk_i = 1'b1;
    pwm_pairs_here_i = 1'b0; pwm_pin7_en_i = 1'b1;
    cycle_and_check("R7 strobes over pwm");
    chk("R7 strobe data", pad_do_o[1:0], 8'h02);
    chk("R9 refclk when pairs away", {7'b0, pad_do_o[3]}, 8'h01);
    chk("R8 pin7 pwm", {7'b0, pad_do_o[7]}, 8'h00);
    pwm_pairs_here_i = 1'b1;
    cycle_and_check("R8 pwm over refclk");
    chk("R8 pwm pin3", {7'b0, pad_do_o[3]}, 8'h00);

    // constrained random
    void'($urandom(32'd1357));
    for (int i = 0; i < 600; i++) begin
      ext_bus_dis_i    = ($urandom_range(0, 9) != 0);
      bus_do_i         = 8'($urandom); bus_oe_i = 1'($urandom);
      strobe_sel_n_i   = ($urandom_range(0, 3) != 0);
      strobe_wr_i      = 1'($urandom); strobe_rd_i = 1'($urandom);
      pwm_pairs_here_i = 1'($urandom); pwm_pin7_en_i = 1'($urandom);
      pwm_do_i         = 8'($urandom);
      pwm_oe_i         = 8'($urandom) & 8'($urandom);
      refclk_en_i      = 1'($urandom); refclk_i = 1'($urandom);
      pin_i            = 8'($urandom);
      addr_i           = 2'($urandom);
      wr_en_i          = ($urandom_range(0, 2) == 0);
      wdata_i          = 8'($urandom);
      cycle_and_check("rand R2 R6 R7 R8 R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule